// File: doc/BRIEF.md
# BCH syndrome computation unit

This block forms the ten syndromes of a received word of the binary (63,36) BCH code that corrects up to five errors. The word arrives one bit per accepted cycle, highest-degree coefficient first. Each bit is folded into five small remainder registers, one for each distinct minimal polynomial over GF(2^6). When the last bit is in, fixed GF(2) mappings evaluate each remainder at the right power of alpha and give S1 to S10. The same bits are shifted into a 63-bit buffer, so that a downstream corrector can flip the erroneous positions.

A controller pulses `start`, streams the 63 bits with `bit_valid` (gaps are allowed), and waits for `done`. At that point `no_error` reports an error-free word. A controller that sees syndromes other than zero passes them to an error-locator solver, which lies outside this block.

The controller has three states. ST_IDLE is entered at reset. ST_COLLECT accepts bits. ST_DONE holds the results. The transitions are:
- IDLE→COLLECT on `start`.
- COLLECT→COLLECT on `start` (restart) or on an accepted bit that is not the last.
- COLLECT→DONE on the 63rd accepted bit.
- DONE→COLLECT on `start`.
- Any state stays where it is when no such event occurs.

Top module: `bch_syndrome`

## Requirements
- R1: After reset, `done` and `no_error` are 0, `syndromes` is all zero and `rx_word` is all zero.
- R2: A `start` pulse clears the remainder registers and `rx_word`, and `done` is 0 in the cycle after it.
- R3: A bit is accepted only in a cycle where `bit_valid` is 1 and `start` is 0, while collecting. Idle gaps do not count. `done` rises in the cycle after the 63rd accepted bit and not earlier.
- R4: When `done` is 1, syndrome i (1..10) is on `syndromes[6*(i-1)+5 : 6*(i-1)]` and equals r(alpha^i). Here r(x) has the first received bit as the x^62 coefficient and the last as x^0. Alpha is a root of 1 + x + x^6, and field element bit k is the coefficient of alpha^k.
- R5: `no_error` is 1 exactly when `done` is 1 and all ten syndromes are zero. Every codeword of the code with generator 1+x+x^4+x^8+x^15+x^17+x^18+x^19+x^21+x^22+x^27 gives `no_error` = 1.
- R6: When `done` is 1, `rx_word[j]` holds the coefficient of x^j of the received word.
- R7: Bits presented in ST_IDLE or ST_DONE without `start` change neither `syndromes` nor `rx_word`, and `done` stays as it was.
- R8: A `start` during collection discards all bits received so far. The results then depend only on the 63 bits that follow.
- R9: A bit presented with `bit_valid` in the same cycle as `start` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new word; clears all state |
| bit_valid | input | 1 | `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Serial received bit, x^62 coefficient first |
| syndromes | output | 60 | S1..S10, 6 bits each, S1 in the low bits |
| no_error | output | 1 | Word complete and all syndromes zero |
| done | output | 1 | 63 bits received, outputs valid |
| rx_word | output | 63 | Buffered received word, bit j = coefficient of x^j |

## Verification
A remainder register that takes one extra, lost or misplaced bit corrupts every syndrome derived from it. It shows as a mismatch against a software Horner evaluation, and as a failed conjugate relation such as S2 = S1^2, in the first cycle `done` is high. A bit counter that is off by one moves the rising edge of `done` by one cycle, so the result is visible in the cycle the 63rd bit is taken. A missed clear on `start` shows up as syndromes other than zero for a clean codeword at the end of the next word.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

    localparam int GF_M    = 6;
    localparam int GF_ORD  = 63;
    localparam int NUM_SYN = 10;
    localparam int NUM_GRP = 5;
    localparam logic [GF_M-1:0] GF_LOW = 6'b000011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DONE
    } syn_state_t;

    function automatic logic [GF_M-1:0] gf_times_alpha(input logic [GF_M-1:0] a);
        return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_LOW : '0);
    endfunction

    function automatic logic [GF_M-1:0] gf_alpha_pow(input int e);
        logic [GF_M-1:0] a;
        a = 6'd1;
        for (int i = 0; i < GF_ORD; i++) begin
            if (i < (e % GF_ORD)) a = gf_times_alpha(a);
        end
        return a;
    endfunction

    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                               input logic [GF_M-1:0] b);
        logic [GF_M-1:0] acc;
        logic [GF_M-1:0] x;
        acc = '0;
        x   = a;
        for (int i = 0; i < GF_M; i++) begin
            if (b[i]) acc = acc ^ x;
            x = gf_times_alpha(x);
        end
        return acc;
    endfunction

endpackage

// File: rtl/bch_rem_lfsr.sv
module bch_rem_lfsr
    import bch_syn_pkg::*;
#(
    parameter int              DEG  = 6,
    parameter logic [GF_M-1:0] POLY = 6'b000011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift,
    input  logic            din,
    output logic [GF_M-1:0] rem
);

    logic [DEG-1:0] r_q;
    logic [DEG-1:0] r_nxt;

    always_comb begin
        r_nxt = {r_q[DEG-2:0], din} ^ (r_q[DEG-1] ? POLY[DEG-1:0] : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     r_q <= '0;
        else if (clr)   r_q <= '0;
        else if (shift) r_q <= r_nxt;
    end

    always_comb begin
        rem          = '0;
        rem[DEG-1:0] = r_q;
    end

    // R2: a clear leaves an empty remainder in the next cycle
    assert_rem_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rem == '0));

endmodule

// File: rtl/bch_syn_eval.sv
module bch_syn_eval
    import bch_syn_pkg::*;
#(
    parameter int POWER = 1
) (
    input  logic [GF_M-1:0] rem,
    output logic [GF_M-1:0] syn
);

    always_comb begin
        syn = '0;
        for (int k = 0; k < GF_M; k++) begin
            if (rem[k]) syn = syn ^ gf_alpha_pow((POWER * k) % GF_ORD);
        end
    end

endmodule

// File: rtl/bch_syndrome.sv
module bch_syndrome
    import bch_syn_pkg::*;
#(
    parameter int CODE_LEN = 63
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      bit_valid,
    input  logic                      bit_in,
    output logic [NUM_SYN*GF_M-1:0]   syndromes,
    output logic                      no_error,
    output logic                      done,
    output logic [CODE_LEN-1:0]       rx_word
);

    localparam int CNT_W = $clog2(CODE_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_LEN - 1);

    localparam int GRP_DEG [NUM_GRP] = '{6, 6, 6, 6, 3};
    localparam logic [GF_M-1:0] GRP_POLY [NUM_GRP] =
        '{6'b000011, 6'b010111, 6'b100111, 6'b001001, 6'b000101};
    localparam int SYN_GRP [NUM_SYN] = '{0, 0, 1, 0, 2, 1, 3, 0, 4, 2};

    syn_state_t       state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic [GF_M-1:0]  rem [NUM_GRP];

    assign accept = (state_q == ST_COLLECT) && bit_valid && !start;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_nxt = ST_COLLECT;
            ST_COLLECT: begin
                if (start)                          state_nxt = ST_COLLECT;
                else if (accept && cnt_q == LAST)   state_nxt = ST_DONE;
            end
            ST_DONE:    if (start) state_nxt = ST_COLLECT;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (state_nxt == ST_DONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rx_word <= '0;
        end else if (start) begin
            cnt_q   <= '0;
            rx_word <= '0;
        end else if (accept) begin
            cnt_q   <= cnt_q + 1'b1;
            rx_word <= {rx_word[CODE_LEN-2:0], bit_in};
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_rem
        bch_rem_lfsr #(
            .DEG  (GRP_DEG[g]),
            .POLY (GRP_POLY[g])
        ) u_rem (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start),
            .shift (accept),
            .din   (bit_in),
            .rem   (rem[g])
        );
    end

    for (genvar i = 0; i < NUM_SYN; i++) begin : g_syn
        bch_syn_eval #(
            .POWER (i + 1)
        ) u_eval (
            .rem (rem[SYN_GRP[i]]),
            .syn (syndromes[GF_M*i +: GF_M])
        );
    end

    always_comb begin
        no_error = done && (syndromes == '0);
    end

    // R3: completion follows an accepted bit
    assert_done_after_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(accept));

    // R2: start drops completion and empties the buffer
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && rx_word == '0));

    // R7: outside collection the results hold
    assert_hold_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && state_q != ST_COLLECT) |=> ($stable(rx_word) && $stable(syndromes)));

    // R4: even syndromes are squares of the lower ones over GF(2^6)
    assert_conjugates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (syndromes[11:6]  == gf_mul(syndromes[5:0],   syndromes[5:0])   &&
                  syndromes[23:18] == gf_mul(syndromes[11:6],  syndromes[11:6])  &&
                  syndromes[35:30] == gf_mul(syndromes[17:12], syndromes[17:12]) &&
                  syndromes[47:42] == gf_mul(syndromes[23:18], syndromes[23:18]) &&
                  syndromes[59:54] == gf_mul(syndromes[29:24], syndromes[29:24])));

    // R5: a clean flag only with a finished word
    assert_clean_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        no_error |-> done);

endmodule

// File: tb/tb_bch_syndrome.sv
module tb_bch_syndrome;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [59:0] syndromes;
    logic        no_error;
    logic        done;
    logic [62:0] rx_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bch_syndrome dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
        .bit_in(bit_in), .syndromes(syndromes), .no_error(no_error),
        .done(done), .rx_word(rx_word)
    );

    localparam logic [26:0] GEN_LOW = 27'h06E8113;

    // {message, error mask}: 0..5 injected errors
    localparam logic [98:0] VEC [8] = '{
        {36'h000000000, 63'h0000000000000000},
        {36'hFFFFFFFFF, 63'h0000000000000000},
        {36'h123456789, 63'h0000000000000001},
        {36'hA5A5A5A5A, 63'h4000000000000000},
        {36'h0F0F0F0F0, 63'h0000010000000008},
        {36'h13579BDF0, 63'h0000000800100020},
        {36'hFEDCBA987, 63'h4000000000000007},
        {36'h2468ACE13, 63'h2004100008000400}
    };

    function automatic logic [5:0] fmul(input logic [5:0] a, input logic [5:0] b);
        logic [5:0] p = 6'd0;
        for (int i = 5; i >= 0; i--) begin
            p = {p[4:0], 1'b0} ^ (p[5] ? 6'h03 : 6'h00);
            if (b[i]) p = p ^ a;
        end
        return p;
    endfunction

    function automatic logic [59:0] ref_syn(input logic [62:0] w);
        logic [59:0] s = '0;
        logic [5:0]  a = 6'd1;
        for (int i = 1; i <= 10; i++) begin
            logic [5:0] acc = 6'd0;
            a = fmul(a, 6'd2);
            for (int j = 62; j >= 0; j--) acc = fmul(acc, a) ^ {5'd0, w[j]};
            s[6*(i-1) +: 6] = acc;
        end
        return s;
    endfunction

    function automatic logic [62:0] encode(input logic [35:0] msg);
        logic [26:0] p = '0;
        for (int k = 35; k >= 0; k--) begin
            logic fb = msg[k] ^ p[26];
            p = {p[25:0], 1'b0} ^ (fb ? GEN_LOW : 27'd0);
        end
        return {msg, p};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic v, input logic b);
        @(negedge clk);
        start = 1'b1; bit_valid = v; bit_in = b;
        @(negedge clk);
        start = 1'b0; bit_valid = 1'b0;
    endtask

    task automatic feed(input logic [62:0] w, input int from_k, input int to_k, input bit gaps);
        for (int k = from_k; k <= to_k; k++) begin
            if (gaps && (k % 5 == 2)) begin
                bit_valid = 1'b0;
                @(negedge clk);
            end
            bit_valid = 1'b1;
            bit_in    = w[62-k];
            @(negedge clk);
        end
        bit_valid = 1'b0;
    endtask

    task automatic check_word(input string tag, input logic [62:0] w);
        logic [59:0] es;
        es = ref_syn(w);
        #1;
        chk({tag, " R3 done"}, {63'd0, done}, 64'd1);
        chk({tag, " R4 syndromes"}, {4'd0, syndromes}, {4'd0, es});
        chk({tag, " R5 no_error"}, {63'd0, no_error}, {63'd0, (es == '0)});
        chk({tag, " R6 rx_word"}, {1'b0, rx_word}, {1'b0, w});
    endtask

    task automatic run_word(input string tag, input logic [62:0] w, input bit gaps);
        pulse_start(1'b0, 1'b0);
        feed(w, 0, 62, gaps);
        check_word(tag, w);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [62:0] w;
        logic [59:0] hold_s;
        logic [62:0] hold_r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 done", {63'd0, done}, 64'd0);
        chk("R1 no_error", {63'd0, no_error}, 64'd0);
        chk("R1 syndromes", {4'd0, syndromes}, 64'd0);
        chk("R1 rx_word", {1'b0, rx_word}, 64'd0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            w = encode(VEC[v][98:63]) ^ VEC[v][62:0];
            run_word($sformatf("vec%0d", v), w, 1'b0);
        end

        // R5 clean codeword gives zero syndromes by code theory
        w = encode(36'h9C3E1B7D5);
        run_word("R5 codeword", w, 1'b0);
        chk("R5 zero syndromes", {4'd0, syndromes}, 64'd0);
        chk("R5 flag set", {63'd0, no_error}, 64'd1);

        // random words with 0..5 errors
        for (int n = 0; n < 24; n++) begin
            logic [62:0] mask = '0;
            w = encode({$urandom, $urandom}[35:0]);
            while ($countones(mask) < (n % 6)) mask[$urandom % 63] = 1'b1;
            run_word($sformatf("rand%0d", n), w ^ mask, 1'b0);
        end

        // R3: gaps do not count; done not before the 63rd bit
        w = encode(36'h55AA33CC0) ^ 63'h0000000000F00000;
        pulse_start(1'b0, 1'b0);
        feed(w, 0, 61, 1'b1);
        #1;
        chk("R3 not done after 62 bits", {63'd0, done}, 64'd0);
        feed(w, 62, 62, 1'b0);
        check_word("R3 gaps", w);

        // R7: bits while done are ignored
        hold_s = syndromes;
        hold_r = rx_word;
        feed(63'h7FFFFFFFFFFFFFFF, 0, 9, 1'b0);
        #1;
        chk("R7 syndromes held", {4'd0, syndromes}, {4'd0, hold_s});
        chk("R7 rx_word held", {1'b0, rx_word}, {1'b0, hold_r});
        chk("R7 done held", {63'd0, done}, 64'd1);

        // R2 / R8: start clears, restart mid-word discards prefix
        pulse_start(1'b0, 1'b0);
        #1;
        chk("R2 done cleared", {63'd0, done}, 64'd0);
        chk("R2 rx_word cleared", {1'b0, rx_word}, 64'd0);
        feed(63'h5A5A5A5A5A5A5A5A, 0, 19, 1'b0);
        w = encode(36'h0DEADBEEF) ^ 63'h0000000000000100;
        run_word("R8 restart", w, 1'b0);

        // R9: bit alongside start is discarded
        w = encode(36'h31415926A) ^ 63'h0000800000000002;
        pulse_start(1'b1, 1'b1);
        feed(w, 0, 62, 1'b0);
        check_word("R9 start bit", w);

        // R7 in idle: reset, then bits without start
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        feed(63'h7FFFFFFFFFFFFFFF, 0, 9, 1'b0);
        #1;
        chk("R7 idle rx_word", {1'b0, rx_word}, 64'd0);
        chk("R7 idle syndromes", {4'd0, syndromes}, 64'd0);
        chk("R7 idle done", {63'd0, done}, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule